// File: doc/BRIEF.md
# Four-Port Arbitrated Node Memory

A shared store for node values, reached through four independent request/acknowledge ports. A requester raises its enable together with the direction, the word address and (for a store) the data word. The memory answers with an acknowledge that stays high until the requester lets go of enable. Any number of loads are served on the same clock edge. Stores are serialized: at most one of them commits per edge, and a rotating priority decides the order when several are waiting.

Each word has a timestamp beside it. On every committed store the timestamp takes the value of a free-running time input. Ports 2 and 3 are producer ports: they may only store into words whose bit in a permission bitmap is set. The bitmap is loaded through a separate one-bit table-write input. Ports 0 and 1 always have store access. A load returns both the data word and its timestamp.

Top module: `nodemem`

## Requirements
- R1: During and after synchronous reset every ack bit is 0, every dout and tout is 0, the arbitration pointer is 0, and every permission bit is 1 (writable).
- R2: A load (en=1, we=0) on a port whose ack is low is granted at the next rising edge, whatever the other ports are doing. After that edge ack is 1, and dout/tout carry the data and timestamp of the addressed word.
- R3: While en stays high, ack stays 1, dout and tout hold their values and the operation is not repeated. ack returns to 0 at the first edge at which en is sampled low.
- R4: At most one store commits per edge. Among the pending stores (en=1, we=1, ack=0), the winner is the first port found at or after the pointer, counting upward modulo 4. The winner's ack rises after that edge and the pointer moves to winner+1 modulo 4. Loads do not move the pointer.
- R5: A committed store records, next to the data word, the value that time_in has at the committing edge.
- R6: A store from port 2 or port 3 to a word whose permission bit is 0 is still acknowledged under R4, but leaves that word's data and timestamp unchanged.
- R7: Stores from port 0 and port 1 commit regardless of the permission bitmap.
- R8: With tab_we=1 at a rising edge, the permission bit at tab_addr takes the value tab_bit. The new bit governs stores that commit at later edges.
- R9: A load granted at the same edge as a committed store to the same address returns the word's content from before that store.
- R10: A store does not change the dout and tout of the port that issued it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 4 | Per-port request enable |
| we | input | 4 | Per-port direction, 1 = store |
| addr | input | 4 x AW | Per-port word address |
| din | input | 4 x DW | Per-port store data |
| ack | output | 4 | Per-port grant, held while en stays high |
| dout | output | 4 x DW | Per-port loaded data word |
| tout | output | 4 x TW | Per-port loaded timestamp |
| time_in | input | TW | Free-running time value |
| tab_we | input | 1 | Permission table write strobe |
| tab_addr | input | AW | Permission table word address |
| tab_bit | input | 1 | Permission value, 1 = writable |

## Verification
A load's ack, dout and tout are due one edge after enable is first sampled. A lone store's ack is also due one edge later. With k contending stores, one more ack appears at each of k consecutive edges, in pointer order. The ack is due to fall one edge after enable is sampled low. The bench drives inputs on falling edges and samples 1 ns after each rising edge. During contention it samples every edge and compares the whole ack vector with the grant order worked out from its own pointer model. Stored data and timestamps are checked only through later loads, each compared with a model that records time_in at the sampled commit edge.

// File: rtl/nodemem_pkg.sv
package nodemem_pkg;

    localparam int NPORT = 4;
    localparam int PW    = $clog2(NPORT);

    // classification of one port's request in the current cycle
    typedef enum logic [1:0] {
        REQ_NONE  = 2'd0,
        REQ_LOAD  = 2'd1,
        REQ_STORE = 2'd2,
        REQ_HELD  = 2'd3
    } req_kind_e;

    function automatic req_kind_e classify(input logic en_i, input logic we_i,
                                           input logic ack_i);
        if (!en_i)
            return REQ_NONE;
        else if (ack_i)
            return REQ_HELD;
        else if (we_i)
            return REQ_STORE;
        else
            return REQ_LOAD;
    endfunction

    // first requester at or after ptr, searching upward with wrap
    function automatic logic [NPORT-1:0] rr_pick(input logic [NPORT-1:0] req,
                                                 input logic [PW-1:0] ptr);
        logic [NPORT-1:0] pick;
        logic             found;
        pick  = '0;
        found = 1'b0;
        for (int k = 0; k < NPORT; k++) begin
            int idx;
            idx = (int'(ptr) + k) % NPORT;
            if (req[idx] && !found) begin
                pick[idx] = 1'b1;
                found     = 1'b1;
            end
        end
        return pick;
    endfunction

    function automatic logic [PW-1:0] onehot_to_idx(input logic [NPORT-1:0] oh);
        logic [PW-1:0] idx;
        idx = '0;
        for (int k = 0; k < NPORT; k++)
            if (oh[k]) idx = PW'(k);
        return idx;
    endfunction

endpackage

// File: rtl/nmem_wr_arb.sv
module nmem_wr_arb
    import nodemem_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [NPORT-1:0] req,
    output logic [NPORT-1:0] grant,
    output logic [PW-1:0]    win_idx
);

    logic [PW-1:0] ptr_q;

    always_comb begin
        grant   = rr_pick(req, ptr_q);
        win_idx = onehot_to_idx(grant);
    end

    always_ff @(posedge clk) begin
        if (rst)
            ptr_q <= '0;
        else if (|req)
            ptr_q <= (int'(win_idx) == NPORT - 1) ? '0 : win_idx + PW'(1);
    end

    // R4
    one_store_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

    // R4
    grant_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
        (grant & ~req) == '0);

    // R4
    no_idle_grant_chk: assert property (@(posedge clk) disable iff (rst)
        (|req) |-> $countones(grant) == 1);

    // R4
    ptr_moves_chk: assert property (@(posedge clk) disable iff (rst)
        (|req) |=> ptr_q != $past(win_idx));

endmodule

// File: rtl/nmem_permtab.sv
module nmem_permtab
    import nodemem_pkg::*;
#(
    parameter int               DEPTH = 1024,
    parameter logic [NPORT-1:0] GATED = 4'b1100,
    localparam int              AW    = $clog2(DEPTH)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      tab_we,
    input  logic [AW-1:0]             tab_addr,
    input  logic                      tab_bit,
    input  logic [NPORT-1:0][AW-1:0]  chk_addr,
    output logic [NPORT-1:0]          allow
);

    logic [DEPTH-1:0] perm_q;

    always_ff @(posedge clk) begin
        if (rst)
            perm_q <= '1;
        else if (tab_we)
            perm_q[tab_addr] <= tab_bit;
    end

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        if (GATED[p]) begin : g_gated
            assign allow[p] = perm_q[chk_addr[p]];
        end else begin : g_free
            assign allow[p] = 1'b1;
        end
    end

    // R8
    tab_load_chk: assert property (@(posedge clk) disable iff (rst)
        tab_we |=> perm_q[$past(tab_addr)] == $past(tab_bit));

    // R8
    tab_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !tab_we |=> $stable(perm_q));

endmodule

// File: rtl/nmem_store.sv
module nmem_store
    import nodemem_pkg::*;
#(
    parameter int  DEPTH = 1024,
    parameter int  DW    = 32,
    parameter int  TW    = 32,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_en,
    input  logic [AW-1:0]             wr_addr,
    input  logic [DW-1:0]             wr_data,
    input  logic [TW-1:0]             wr_time,
    input  logic [NPORT-1:0][AW-1:0]  rd_addr,
    output logic [NPORT-1:0][DW-1:0]  rd_data,
    output logic [NPORT-1:0][TW-1:0]  rd_time
);

    logic [DW-1:0] data_mem [DEPTH];
    logic [TW-1:0] time_mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            data_mem[wr_addr] <= wr_data;
            time_mem[wr_addr] <= wr_time;
        end
    end

    for (genvar p = 0; p < NPORT; p++) begin : g_rd
        assign rd_data[p] = data_mem[rd_addr[p]];
        assign rd_time[p] = time_mem[rd_addr[p]];
    end

    // R5
    commit_data_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> data_mem[$past(wr_addr)] == $past(wr_data));

    // R5
    commit_time_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> time_mem[$past(wr_addr)] == $past(wr_time));

endmodule

// File: rtl/nodemem.sv
module nodemem
    import nodemem_pkg::*;
#(
    parameter int               DEPTH = 1024,
    parameter int               DW    = 32,
    parameter int               TW    = 32,
    parameter logic [NPORT-1:0] GATED = 4'b1100,
    localparam int              AW    = $clog2(DEPTH)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NPORT-1:0]          en,
    input  logic [NPORT-1:0]          we,
    input  logic [NPORT-1:0][AW-1:0]  addr,
    input  logic [NPORT-1:0][DW-1:0]  din,
    output logic [NPORT-1:0]          ack,
    output logic [NPORT-1:0][DW-1:0]  dout,
    output logic [NPORT-1:0][TW-1:0]  tout,
    input  logic [TW-1:0]             time_in,
    input  logic                      tab_we,
    input  logic [AW-1:0]             tab_addr,
    input  logic                      tab_bit
);

    typedef struct packed {
        logic          valid;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } store_cmd_t;

    req_kind_e [NPORT-1:0]   kind;
    logic [NPORT-1:0]        st_req;
    logic [NPORT-1:0]        ld_go;
    logic [NPORT-1:0]        st_grant;
    logic [PW-1:0]           st_win;
    logic [NPORT-1:0]        allow;
    logic [NPORT-1:0][DW-1:0] mem_rd;
    logic [NPORT-1:0][TW-1:0] mem_rt;
    store_cmd_t              cmd;
    logic [NPORT-1:0]        ack_q;
    logic [NPORT-1:0][DW-1:0] dout_q;
    logic [NPORT-1:0][TW-1:0] tout_q;

    for (genvar p = 0; p < NPORT; p++) begin : g_cls
        assign kind[p]   = classify(en[p], we[p], ack_q[p]);
        assign st_req[p] = (kind[p] == REQ_STORE);
        assign ld_go[p]  = (kind[p] == REQ_LOAD);
    end

    nmem_wr_arb u_arb (
        .clk     (clk),
        .rst     (rst),
        .req     (st_req),
        .grant   (st_grant),
        .win_idx (st_win)
    );

    nmem_permtab #(.DEPTH(DEPTH), .GATED(GATED)) u_perm (
        .clk      (clk),
        .rst      (rst),
        .tab_we   (tab_we),
        .tab_addr (tab_addr),
        .tab_bit  (tab_bit),
        .chk_addr (addr),
        .allow    (allow)
    );

    always_comb begin
        cmd.valid = (|st_grant) && allow[st_win];
        cmd.addr  = addr[st_win];
        cmd.data  = din[st_win];
    end

    nmem_store #(.DEPTH(DEPTH), .DW(DW), .TW(TW)) u_mem (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cmd.valid),
        .wr_addr (cmd.addr),
        .wr_data (cmd.data),
        .wr_time (time_in),
        .rd_addr (addr),
        .rd_data (mem_rd),
        .rd_time (mem_rt)
    );

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        always_ff @(posedge clk) begin
            if (rst) begin
                ack_q[p]  <= 1'b0;
                dout_q[p] <= '0;
                tout_q[p] <= '0;
            end else begin
                if (!en[p])
                    ack_q[p] <= 1'b0;
                else if (ld_go[p] || st_grant[p])
                    ack_q[p] <= 1'b1;
                if (ld_go[p]) begin
                    dout_q[p] <= mem_rd[p];
                    tout_q[p] <= mem_rt[p];
                end
            end
        end

        // R2
        ack_cause_chk: assert property (@(posedge clk) disable iff (rst)
            $rose(ack[p]) |-> $past(en[p]));

        // R3
        ack_hold_chk: assert property (@(posedge clk) disable iff (rst)
            (en[p] && ack[p]) |=> ack[p]);

        // R3
        ack_drop_chk: assert property (@(posedge clk) disable iff (rst)
            !en[p] |=> !ack[p]);

        // R3
        out_stable_chk: assert property (@(posedge clk) disable iff (rst)
            (en[p] && ack[p]) |=> ($stable(dout[p]) && $stable(tout[p])));

        // R10
        store_keeps_out_chk: assert property (@(posedge clk) disable iff (rst)
            (en[p] && we[p]) |=> ($stable(dout[p]) && $stable(tout[p])));
    end

    assign ack  = ack_q;
    assign dout = dout_q;
    assign tout = tout_q;

endmodule

// File: tb/nodemem_test.sv
`timescale 1ns/100ps
module nodemem_test;
    import nodemem_pkg::*;

    localparam int DEPTH = 16;
    localparam int DW    = 16;
    localparam int TW    = 16;
    localparam int AW    = 4;

    logic                     clk = 1'b0;
    logic                     rst = 1'b1;
    logic [NPORT-1:0]         en  = '0;
    logic [NPORT-1:0]         we  = '0;
    logic [NPORT-1:0][AW-1:0] addr = '0;
    logic [NPORT-1:0][DW-1:0] din  = '0;
    logic [NPORT-1:0]         ack;
    logic [NPORT-1:0][DW-1:0] dout;
    logic [NPORT-1:0][TW-1:0] tout;
    logic [TW-1:0]            tnow = '0;
    logic                     tab_we = 1'b0;
    logic [AW-1:0]            tab_addr = '0;
    logic                     tab_bit = 1'b0;

    always #2.5 clk = ~clk;
    always @(negedge clk) tnow <= tnow + 1'b1;

    nodemem #(.DEPTH(DEPTH), .DW(DW), .TW(TW), .GATED(4'b1100)) uut (
        .clk(clk), .rst(rst), .en(en), .we(we), .addr(addr), .din(din),
        .ack(ack), .dout(dout), .tout(tout), .time_in(tnow),
        .tab_we(tab_we), .tab_addr(tab_addr), .tab_bit(tab_bit)
    );

    int            n_chk = 0;
    int            n_bad = 0;
    bit            finished = 1'b0;
    logic [DW-1:0] m_data [DEPTH];
    logic [TW-1:0] m_ts   [DEPTH];
    logic          m_perm [DEPTH];
    int            ptr_m = 0;
    logic [DW-1:0] last_d [NPORT];
    logic [TW-1:0] last_t [NPORT];
    logic [AW-1:0] ca [NPORT];
    logic [DW-1:0] cd [NPORT];

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit may_write(input int p, input int a);
        return (p < 2) || m_perm[a];
    endfunction

    task automatic op(input int p, input bit w, input int a, input logic [DW-1:0] d,
                      input string tag);
        @(negedge clk);
        en[p] = 1'b1; we[p] = w; addr[p] = AW'(a); din[p] = d;
        @(posedge clk); #1;
        chk(ack[p] === 1'b1, w ? "R4 lone store ack" : "R2 load ack", ack[p], 1);
        if (w) begin
            chk(dout[p] === last_d[p] && tout[p] === last_t[p], "R10 store keeps dout",
                dout[p], last_d[p]);
            if (may_write(p, a)) begin
                m_data[a] = d;
                m_ts[a]   = tnow;
            end
            ptr_m = (p + 1) % NPORT;
        end else begin
            chk(dout[p] === m_data[a], tag, dout[p], m_data[a]);
            chk(tout[p] === m_ts[a], "R5 timestamp", tout[p], m_ts[a]);
            last_d[p] = dout[p];
            last_t[p] = tout[p];
        end
        @(posedge clk); #1;
        chk(ack[p] === 1'b1, "R3 ack held", ack[p], 1);
        chk(dout[p] === last_d[p], "R3 dout held", dout[p], last_d[p]);
        @(negedge clk);
        en[p] = 1'b0;
        @(posedge clk); #1;
        chk(ack[p] === 1'b0, "R3 ack released", ack[p], 0);
    endtask

    task automatic tab_set(input int a, input bit b);
        @(negedge clk);
        tab_we = 1'b1; tab_addr = AW'(a); tab_bit = b;
        @(negedge clk);
        tab_we = 1'b0;
        m_perm[a] = b;
    endtask

    task automatic store_all();
        logic [NPORT-1:0] pend;
        logic [NPORT-1:0] exp_ack;
        @(negedge clk);
        for (int p = 0; p < NPORT; p++) begin
            en[p] = 1'b1; we[p] = 1'b1; addr[p] = ca[p]; din[p] = cd[p];
        end
        pend    = '1;
        exp_ack = '0;
        repeat (NPORT) begin
            int w;
            bit got;
            w   = 0;
            got = 1'b0;
            @(posedge clk); #1;
            for (int k = 0; k < NPORT; k++) begin
                int idx;
                idx = (ptr_m + k) % NPORT;
                if (pend[idx] && !got) begin
                    w   = idx;
                    got = 1'b1;
                end
            end
            exp_ack[w] = 1'b1;
            pend[w]    = 1'b0;
            if (may_write(w, int'(ca[w]))) begin
                m_data[ca[w]] = cd[w];
                m_ts[ca[w]]   = tnow;
            end
            ptr_m = (w + 1) % NPORT;
            chk(ack === exp_ack, "R4 grant order", ack, exp_ack);
        end
        @(negedge clk);
        en = '0;
        @(posedge clk); #1;
        chk(ack === 4'h0, "R3 all released", ack, 0);
    endtask

    task automatic load_all(input string tag);
        @(negedge clk);
        for (int p = 0; p < NPORT; p++) begin
            en[p] = 1'b1; we[p] = 1'b0; addr[p] = ca[p];
        end
        @(posedge clk); #1;
        chk(ack === 4'hF, "R2 parallel loads", ack, 4'hF);
        for (int p = 0; p < NPORT; p++) begin
            chk(dout[p] === m_data[ca[p]], tag, dout[p], m_data[ca[p]]);
            chk(tout[p] === m_ts[ca[p]], "R5 parallel timestamp", tout[p], m_ts[ca[p]]);
            last_d[p] = dout[p];
            last_t[p] = tout[p];
        end
        @(negedge clk);
        en = '0;
        @(posedge clk); #1;
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        for (int a = 0; a < DEPTH; a++) begin
            m_data[a] = '0; m_ts[a] = '0; m_perm[a] = 1'b1;
        end
        for (int p = 0; p < NPORT; p++) begin
            last_d[p] = '0; last_t[p] = '0;
        end
        repeat (3) @(posedge clk);
        #1;
        // R1: outputs while reset is held
        chk(ack === 4'h0, "R1 ack in reset", ack, 0);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk); #1;
        chk(ack === 4'h0, "R1 ack after reset", ack, 0);
        for (int p = 0; p < NPORT; p++) begin
            chk(dout[p] === '0, "R1 dout zero", dout[p], 0);
            chk(tout[p] === '0, "R1 tout zero", tout[p], 0);
        end

        // fill every word, rotating the port; gated ports rely on the R1 all-writable reset
        for (int a = 0; a < DEPTH; a++)
            op(a % NPORT, 1'b1, a, DW'(16'h1000 + a * 16'h0111), "");
        for (int p = 0; p < NPORT; p++)
            for (int a = 0; a < DEPTH; a++)
                op(p, 1'b0, a, '0, "R1 R2 load sweep");

        // R8: clear permission on odd words and on word 0
        for (int a = 1; a < DEPTH; a += 2)
            tab_set(a, 1'b0);
        tab_set(0, 1'b0);

        // R6: gated ports over every word
        for (int a = 0; a < DEPTH; a++) begin
            op(2, 1'b1, a, DW'(16'h2000 + a), "");
            op(3, 1'b1, a, DW'(16'h3000 + a), "");
        end
        for (int a = 0; a < DEPTH; a++)
            op(a % NPORT, 1'b0, a, '0, "R6 gated store result");

        // R7: free ports ignore the bitmap
        for (int a = 0; a < DEPTH; a += 1)
            if (a % 2 == 1 || a == 0)
                op((a >> 1) % 2, 1'b1, a, DW'(16'h4000 + a), "");
        for (int a = 0; a < DEPTH; a++)
            op((a + 1) % NPORT, 1'b0, a, '0, "R7 free store result");

        // R8: restore word 1, gated store now lands
        tab_set(1, 1'b1);
        op(2, 1'b1, 1, 16'h5A5A, "");
        op(0, 1'b0, 1, '0, "R8 re-enabled word");
        op(3, 1'b1, 0, 16'h6B6B, "");
        op(1, 1'b0, 0, '0, "R8 still protected word");

        // R4: four stores at once, distinct words, two of them denied
        ca[0] = 4'd2; ca[1] = 4'd5; ca[2] = 4'd7; ca[3] = 4'd9;
        for (int p = 0; p < NPORT; p++) cd[p] = DW'(16'h7000 + p);
        store_all();
        load_all("R4 R6 contention result");

        // R4: move the pointer then collide on one word
        op(1, 1'b1, 12, 16'h0C0C, "");
        for (int p = 0; p < NPORT; p++) begin
            ca[p] = 4'd4;
            cd[p] = DW'(16'h8000 + p);
        end
        store_all();
        load_all("R4 last granted store wins");

        // R4: another collision from a different pointer position
        op(2, 1'b1, 6, 16'h0606, "");
        for (int p = 0; p < NPORT; p++) begin
            ca[p] = AW'(8 + 2 * p);
            cd[p] = DW'(16'h9000 + p);
        end
        store_all();
        load_all("R4 rotated contention result");

        // R9: load and store to one word on the same edge
        begin
            logic [DW-1:0] old_v;
            old_v = m_data[10];
            @(negedge clk);
            en[0] = 1'b1; we[0] = 1'b1; addr[0] = 4'd10; din[0] = 16'hBEEF;
            en[1] = 1'b1; we[1] = 1'b0; addr[1] = 4'd10;
            @(posedge clk); #1;
            chk(dout[1] === old_v, "R9 load sees prior word", dout[1], old_v);
            chk(ack[1:0] === 2'b11, "R2 R4 mixed grant", ack[1:0], 2'b11);
            m_data[10] = 16'hBEEF;
            m_ts[10]   = tnow;
            ptr_m      = 1;
            last_d[1]  = dout[1];
            last_t[1]  = tout[1];
            @(negedge clk);
            en = '0;
            @(posedge clk); #1;
        end
        op(3, 1'b0, 10, '0, "R9 store landed");

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule